// File: doc/BRIEF.md
# Power-up reset timeout sequencer

This block decides when the internal reset of a small microcontroller core is released. It starts a chain of delays from a power-on pulse. First comes a power-up timer counted in ticks of a slow reference, with its length set by a parameter. Then comes an oscillator start-up count of `OST_CYCLES` oscillator clocks. Each stage is used or skipped according to the oscillator mode (crystal-type or RC) and the power-up-timer enable bit. The delays do not depend on the external reset pin. If the pin is held low until both delays are over, the core starts on the clock edge after the pin is released.

The block also follows the core through normal operation, sleep, watchdog events and wake-ups. It keeps the two status flags that software reads to learn why the core last reset or woke: a timeout flag (`flag_to`) and a power-down flag (`flag_pd`). The power-on pulse acts as an asynchronous reset and restarts everything. The watchdog counter, the oscillator and voltage sensing are outside the block. Their results arrive as single-cycle event inputs.

States:
- `S_BOOT`: first clock after power-on. It picks the first stage.
- `S_PWRT`: counts `PWRT_TICKS` reference ticks.
- `S_OST`: counts `OST_CYCLES` clocks.
- `S_HOLD`: timers are done and the pin is still low.
- `S_RUN`: normal execution.
- `S_WDTRST`: one-cycle watchdog reset.
- `S_SLEEP`: core asleep.

Transitions:
- `S_BOOT` goes to `S_PWRT` if the timer is enabled. Otherwise it goes to `S_OST` in crystal mode. Otherwise it finishes.
- `S_PWRT` goes to `S_OST` (crystal) or finishes (RC) on its last tick.
- `S_OST` finishes on its last count.
- `S_HOLD` goes to `S_RUN` when the pin is high.
- `S_RUN` goes to `S_HOLD` on pin low. Otherwise it goes to `S_WDTRST` on a watchdog timeout. Otherwise it goes to `S_SLEEP` on a sleep command.
- `S_WDTRST` finishes.
- `S_SLEEP` wakes on pin low, watchdog timeout or interrupt, to `S_OST` (crystal) or finish (RC).

"Finishing" means going to `S_RUN` when the pin is high and to `S_HOLD` otherwise.

Top module: `rst_seq_top`

## Requirements
- R1: While `por_i` is high and after it falls, `core_rst`=1, `flag_to`=1, `flag_pd`=1 and `asleep`=0, until the sequence ends.
- R2: In crystal mode (`osc_rc`=0) with `pwrt_en`=1 and `tick_i` held high, `core_rst` falls at the 1+PWRT_TICKS+OST_CYCLES-th rising clock edge after `por_i` falls.
- R3: In crystal mode with `pwrt_en`=0, `core_rst` falls at edge 1+OST_CYCLES after `por_i` falls.
- R4: In RC mode (`osc_rc`=1) with `pwrt_en`=1, `core_rst` falls at edge 1+PWRT_TICKS. The power-up timer advances only on clocks where `tick_i`=1.
- R5: In RC mode with `pwrt_en`=0, `core_rst` falls at the first edge after `por_i` falls.
- R6: The delays do not wait for `ext_rst_n`. If the pin is low after both delays are over, `core_rst` stays 1, and it falls at the first edge at which the pin is high.
- R7: Pin low during normal operation raises `core_rst` at the next edge and keeps it high while the pin is low, without changing `flag_to`/`flag_pd`. `core_rst` falls at the first edge with the pin high.
- R8: A `wdt_expire` during normal operation gives exactly one cycle of `core_rst`=1 and sets `flag_to`=0, `flag_pd`=1.
- R9: `sleep_cmd` during normal operation sets `asleep`=1, `flag_to`=1, `flag_pd`=0 at the next edge. `wdt_clear` sets `flag_to`=1, `flag_pd`=1. Priority in normal operation is pin low, then `wdt_expire`, then `sleep_cmd`, then `wdt_clear`.
- R10: A `wdt_expire` in sleep wakes the core with `flag_to`=0, `flag_pd`=0. In crystal mode `core_rst` is 1 from the wake edge and falls at edge 1+OST_CYCLES counted from the event. In RC mode `core_rst` stays 0.
- R11: An interrupt wake (`wake_irq`) or pin low during sleep gives `flag_to`=1, `flag_pd`=0. With pin low, `core_rst` is 1 until the pin returns high.
- R12: A new `por_i` pulse in the middle of the sequence restarts both counters, so the full R2 delay is measured again from its falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous reset of the block |
| ext_rst_n | input | 1 | External reset pin, active low |
| osc_rc | input | 1 | Oscillator mode: 1 = RC, 0 = crystal-type |
| pwrt_en | input | 1 | Power-up timer enable |
| tick_i | input | 1 | One-clock pulse of the slow reference |
| wdt_expire | input | 1 | Watchdog timeout event |
| sleep_cmd | input | 1 | Core requests sleep |
| wdt_clear | input | 1 | Core clears the watchdog |
| wake_irq | input | 1 | Interrupt wake-up event |
| core_rst | output | 1 | Registered internal reset / hold of the core |
| asleep | output | 1 | Core is in sleep |
| flag_to | output | 1 | Timeout status flag |
| flag_pd | output | 1 | Power-down status flag |

## Verification
A wrong state shows at `core_rst` one edge after the transition that caused it. An unwanted stay in a timer state shows up as a release delay that differs from the expected count by that many edges. A wrong sleep or wake decision shows on `asleep` and on the flag pair at the next edge. Flag errors stay visible until the next event, so every check is made at the single cycle where each event's effect first appears.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        S_BOOT   = 3'd0,
        S_PWRT   = 3'd1,
        S_OST    = 3'd2,
        S_HOLD   = 3'd3,
        S_RUN    = 3'd4,
        S_WDTRST = 3'd5,
        S_SLEEP  = 3'd6
    } seq_state_e;

endpackage

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
    parameter int PWRT_TICKS = 72000,
    parameter int OST_CYCLES = 1024
) (
    input  logic clk,
    input  logic por_i,
    input  logic run_pwrt,
    input  logic run_ost,
    input  logic tick_i,
    output logic pwrt_done,
    output logic ost_done
);
    localparam int CNT_MAX = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
    localparam int CW      = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
    localparam logic [CW-1:0] PWRT_LAST = CW'(PWRT_TICKS - 1);
    localparam logic [CW-1:0] OST_LAST  = CW'(OST_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          step;

    // one shared counter: the two stages never run at the same time
    assign step      = (run_pwrt && tick_i) || run_ost;
    assign pwrt_done = run_pwrt && tick_i && (cnt_q == PWRT_LAST);
    assign ost_done  = run_ost && (cnt_q == OST_LAST);

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            cnt_q <= '0;
        end else if (step) begin
            if (pwrt_done || ost_done) cnt_q <= '0;
            else                       cnt_q <= cnt_q + CW'(1);
        end
    end

    AST_PWRT_TICK_ONLY: assert property (@(posedge clk) disable iff (por_i)
        (run_pwrt && !run_ost && !tick_i) |=> $stable(cnt_q)); // R4
    AST_STAGE_WRAP: assert property (@(posedge clk) disable iff (por_i)
        (pwrt_done || ost_done) |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/rst_seq_flags.sv
module rst_seq_flags (
    input  logic clk,
    input  logic por_i,
    input  logic ev_wdt_rst,
    input  logic ev_wdt_wake,
    input  logic ev_sleep,
    input  logic ev_clr,
    input  logic ev_plain_wake,
    output logic flag_to,
    output logic flag_pd
);
    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            flag_to <= 1'b1;
            flag_pd <= 1'b1;
        end else if (ev_wdt_rst) begin
            flag_to <= 1'b0;
            flag_pd <= 1'b1;
        end else if (ev_wdt_wake) begin
            flag_to <= 1'b0;
            flag_pd <= 1'b0;
        end else if (ev_sleep || ev_plain_wake) begin
            flag_to <= 1'b1;
            flag_pd <= 1'b0;
        end else if (ev_clr) begin
            flag_to <= 1'b1;
            flag_pd <= 1'b1;
        end
    end

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (por_i)
        $onehot0({ev_wdt_rst, ev_wdt_wake, ev_sleep, ev_clr, ev_plain_wake})); // R9
    AST_WDT_RST_FLAGS: assert property (@(posedge clk) disable iff (por_i)
        ev_wdt_rst |=> (!flag_to && flag_pd)); // R8

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
    parameter int PWRT_TICKS = 72000,
    parameter int OST_CYCLES = 1024
) (
    input  logic clk,
    input  logic por_i,
    input  logic ext_rst_n,
    input  logic osc_rc,
    input  logic pwrt_en,
    input  logic tick_i,
    input  logic wdt_expire,
    input  logic sleep_cmd,
    input  logic wdt_clear,
    input  logic wake_irq,
    output logic core_rst,
    output logic asleep,
    output logic flag_to,
    output logic flag_pd
);
    import rst_seq_pkg::*;

    seq_state_e state_q, state_n, finish_st, wake_st;
    logic pwrt_done, ost_done;
    logic ev_wdt_rst, ev_wdt_wake, ev_sleep, ev_clr, ev_plain_wake;
    logic in_run, in_sleep;

    assign in_run   = (state_q == S_RUN);
    assign in_sleep = (state_q == S_SLEEP);

    rst_seq_timer #(
        .PWRT_TICKS (PWRT_TICKS),
        .OST_CYCLES (OST_CYCLES)
    ) u_timer (
        .clk       (clk),
        .por_i     (por_i),
        .run_pwrt  (state_q == S_PWRT),
        .run_ost   (state_q == S_OST),
        .tick_i    (tick_i),
        .pwrt_done (pwrt_done),
        .ost_done  (ost_done)
    );

    // event decode, priority: pin, watchdog, sleep, clear
    assign ev_wdt_rst    = in_run && ext_rst_n && wdt_expire;
    assign ev_sleep      = in_run && ext_rst_n && !wdt_expire && sleep_cmd;
    assign ev_clr        = in_run && ext_rst_n && !wdt_expire && !sleep_cmd && wdt_clear;
    assign ev_wdt_wake   = in_sleep && ext_rst_n && wdt_expire;
    assign ev_plain_wake = in_sleep && (!ext_rst_n || (!wdt_expire && wake_irq));

    rst_seq_flags u_flags (
        .clk           (clk),
        .por_i         (por_i),
        .ev_wdt_rst    (ev_wdt_rst),
        .ev_wdt_wake   (ev_wdt_wake),
        .ev_sleep      (ev_sleep),
        .ev_clr        (ev_clr),
        .ev_plain_wake (ev_plain_wake),
        .flag_to       (flag_to),
        .flag_pd       (flag_pd)
    );

    assign finish_st = ext_rst_n ? S_RUN : S_HOLD;
    assign wake_st   = osc_rc ? finish_st : S_OST;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_BOOT: begin
                if (pwrt_en)      state_n = S_PWRT;
                else              state_n = wake_st;
            end
            S_PWRT:   if (pwrt_done) state_n = wake_st;
            S_OST:    if (ost_done)  state_n = finish_st;
            S_HOLD:   if (ext_rst_n) state_n = S_RUN;
            S_RUN: begin
                if (!ext_rst_n)      state_n = S_HOLD;
                else if (wdt_expire) state_n = S_WDTRST;
                else if (sleep_cmd)  state_n = S_SLEEP;
            end
            S_WDTRST: state_n = finish_st;
            S_SLEEP:  if (ev_wdt_wake || ev_plain_wake) state_n = wake_st;
            default:  state_n = S_BOOT;
        endcase
    end

    // state register
    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) state_q <= S_BOOT;
        else       state_q <= state_n;
    end

    // registered outputs
    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            core_rst <= 1'b1;
            asleep   <= 1'b0;
        end else begin
            core_rst <= !((state_n == S_RUN) || (state_n == S_SLEEP));
            asleep   <= (state_n == S_SLEEP);
        end
    end

    AST_BOOT_FLAGS: assert property (@(posedge clk) disable iff (por_i)
        (state_q == S_BOOT) |-> (flag_to && flag_pd && core_rst)); // R1
    AST_PIN_HOLDS_RST: assert property (@(posedge clk) disable iff (por_i)
        !ext_rst_n |=> core_rst); // R6
    AST_EXT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (por_i)
        (in_run && !ext_rst_n) |=> ($stable(flag_to) && $stable(flag_pd))); // R7
    AST_SLEEP_FLAGS: assert property (@(posedge clk) disable iff (por_i)
        ev_sleep |=> (asleep && flag_to && !flag_pd)); // R9
    AST_WDT_WAKE_FLAGS: assert property (@(posedge clk) disable iff (por_i)
        ev_wdt_wake |=> (!flag_to && !flag_pd && !asleep)); // R10
    AST_WDTRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (por_i)
        (state_q == S_WDTRST && ext_rst_n) |=> !core_rst); // R8

endmodule

// File: tb/tb_rst_seq_top.sv
module tb_rst_seq_top;
    localparam int P = 40;
    localparam int O = 64;

    logic clk = 1'b0;
    logic por_i = 1'b1, ext_rst_n = 1'b1, osc_rc = 1'b0, pwrt_en = 1'b1, tick_i = 1'b1;
    logic wdt_expire = 1'b0, sleep_cmd = 1'b0, wdt_clear = 1'b0, wake_irq = 1'b0;
    logic core_rst, asleep, flag_to, flag_pd;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    rst_seq_top #(.PWRT_TICKS(P), .OST_CYCLES(O)) dut (
        .clk(clk), .por_i(por_i), .ext_rst_n(ext_rst_n), .osc_rc(osc_rc),
        .pwrt_en(pwrt_en), .tick_i(tick_i), .wdt_expire(wdt_expire),
        .sleep_cmd(sleep_cmd), .wdt_clear(wdt_clear), .wake_irq(wake_irq),
        .core_rst(core_rst), .asleep(asleep), .flag_to(flag_to), .flag_pd(flag_pd)
    );

    // mode table: {osc_rc, pwrt_en}, expected release edge, requirement
    localparam logic [1:0] VEC_MODE [4] = '{2'b01, 2'b00, 2'b11, 2'b10};
    localparam int         VEC_LAT  [4] = '{1 + P + O, 1 + O, 1 + P, 1};
    localparam string      VEC_REQ  [4] = '{"R2", "R3", "R4", "R5"};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic por_pulse();
        @(negedge clk) por_i = 1'b1;
        repeat (2) @(negedge clk);
        por_i = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (core_rst && n < 20000);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk) sig = 1'b1;
        @(negedge clk) sig = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        // R1 reset state
        repeat (2) @(negedge clk);
        chk("R1 core_rst in por", core_rst, 1);
        chk("R1 to in por", flag_to, 1);
        chk("R1 pd in por", flag_pd, 1);
        chk("R1 asleep in por", asleep, 0);

        for (int i = 0; i < 4; i++) begin
            osc_rc  = VEC_MODE[i][1];
            pwrt_en = VEC_MODE[i][0];
            por_pulse();
            measure(n);
            chk({VEC_REQ[i], " release edge"}, n, VEC_LAT[i]);
            chk("R1 flags after por", {flag_to, flag_pd}, 2'b11);
        end

        // R4: no ticks, no progress
        osc_rc = 1'b1; pwrt_en = 1'b1; tick_i = 1'b0;
        por_pulse();
        repeat (3 * P) @(negedge clk);
        chk("R4 held without ticks", core_rst, 1);
        tick_i = 1'b1;
        measure(n);
        chk("R4 release after ticks", n, P);

        // R6: pin held low past both delays
        osc_rc = 1'b0; pwrt_en = 1'b1; ext_rst_n = 1'b0;
        por_pulse();
        repeat (1 + P + O + 20) @(negedge clk);
        chk("R6 held by pin", core_rst, 1);
        ext_rst_n = 1'b1;
        @(negedge clk);
        chk("R6 release next edge", core_rst, 0);

        // R12: restart mid-sequence
        por_pulse();
        repeat (30) @(negedge clk);
        por_pulse();
        measure(n);
        chk("R12 full delay after restart", n, 1 + P + O);

        // R9 sleep, crystal mode
        pulse(sleep_cmd);
        chk("R9 asleep", asleep, 1);
        chk("R9 sleep flags", {flag_to, flag_pd}, 2'b10);
        chk("R9 no reset in sleep", core_rst, 0);

        // R10 watchdog wake in crystal mode
        @(negedge clk) wdt_expire = 1'b1;
        n = 0;
        @(negedge clk) wdt_expire = 1'b0;
        n = 1;
        chk("R10 wake raises reset", core_rst, 1);
        chk("R10 wake flags", {flag_to, flag_pd}, 2'b00);
        chk("R10 awake", asleep, 0);
        while (core_rst && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk("R10 crystal wake delay", n, 1 + O);

        // R9 watchdog clear
        pulse(wdt_clear);
        chk("R9 clear flags", {flag_to, flag_pd}, 2'b11);

        // R8 watchdog reset in run
        pulse(wdt_expire);
        chk("R8 reset pulse", core_rst, 1);
        chk("R8 flags", {flag_to, flag_pd}, 2'b01);
        @(negedge clk);
        chk("R8 single cycle", core_rst, 0);

        // R7 pin in run, flags kept at 01
        @(negedge clk) ext_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 reset while pin low", core_rst, 1);
        chk("R7 flags unchanged", {flag_to, flag_pd}, 2'b01);
        ext_rst_n = 1'b1;
        @(negedge clk);
        chk("R7 release next edge", core_rst, 0);

        // R11 interrupt wake, RC mode
        osc_rc = 1'b1;
        pulse(sleep_cmd);
        pulse(wake_irq);
        chk("R11 irq wake awake", asleep, 0);
        chk("R10 RC wake no reset", core_rst, 0);
        chk("R11 irq wake flags", {flag_to, flag_pd}, 2'b10);

        // R11 pin low in sleep
        pulse(wdt_clear);
        pulse(sleep_cmd);
        @(negedge clk) ext_rst_n = 1'b0;
        @(negedge clk);
        chk("R11 pin wake reset", core_rst, 1);
        chk("R11 pin wake flags", {flag_to, flag_pd}, 2'b10);
        ext_rst_n = 1'b1;
        @(negedge clk);
        chk("R11 pin release", core_rst, 0);

        // R10 watchdog wake, RC mode
        pulse(sleep_cmd);
        pulse(wdt_expire);
        chk("R10 RC wdt wake no reset", core_rst, 0);
        chk("R10 RC wdt wake flags", {flag_to, flag_pd}, 2'b00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule